// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Transmitter

This block serialises words onto a single asynchronous line. Its timing and character length are set by one 32-bit configuration word. The bit period is a clock count with a fractional part. It is held in 16.6 fixed point, which is system clocks times 64 divided by the baud rate. Each new bit time is found by adding that period to the fraction left over from the previous bit. A rate that is not a whole number of clocks therefore keeps its exact average across the frame, with no drift. Each character has one low start bit, then between 1 and 32 data bits sent least significant first, then one high stop bit. The line idles high.

Words enter through a valid/ready stream port. `in_ready` is high only while the transmitter is idle. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. While a frame is in flight, `in_ready` stays low and the source must hold or withdraw its word. `in_data` and `in_valid` have no effect until the frame has ended. The configuration word is sampled when a word is accepted. Changes to it during a frame apply only to the next frame. `busy` is a plain status pin that marks an active frame.

Top module: `fbaud_uart_tx`

## Requirements
- R1: `cfg_word[31:10]` is the bit period P in 16.6 fixed point (clocks × 64). `cfg_word[4:0]` is the data length minus one, so a value of 7 gives 8 data bits. Bits 9:5 are ignored.
- R2: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1. The line is high whenever no frame is active.
- R3: A frame is a start bit of value 0, then the data bits from bit 0 upward, then a stop bit of value 1.
- R4: Call the first cycle of the start bit cycle 0. Bit k of a frame (the start bit is k=0) begins at cycle floor(k·P/64). The whole frame lasts floor((L+3)·P/64) cycles, where L is the length field. Rounding error does not build up across bits.
- R5: A period field below 128 (2.0 clocks), including 0, is treated as exactly 128.
- R6: A word is accepted only on an edge where `in_valid` and `in_ready` are both high. `in_valid` and `in_data` presented while busy cause no extra frame and do not change the frame in flight.
- R7: The period and length that apply to a frame are those on `cfg_word` at its acceptance edge. Changes made during a frame apply from the next frame.
- R8: The length field selects 1 to 32 data bits. Bits of `in_data` above the selected length are not sent.
- R9: `busy` is 1 from the cycle after acceptance through the last stop-bit cycle, then returns to 0. `in_ready` is its inverse, so frames can be sent back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Period (bits 31:10, 16.6) and length minus one (bits 4:0) |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Transmitter can take a word this cycle |
| in_data | input | 32 | Word to send, LSB first |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |

## Verification
Most internal faults show up as timing errors on `txd`. A wrong fractional remainder or a dropped carry moves a bit edge by one cycle, within a few bits of the start. A wrong bit counter stretches or cuts the frame at the stop bit. The monitor compares every cycle of every frame against the edge positions floor(k·P/64). Any such slip therefore fails the frame in which it first appears. A corrupt handshake state shows up as an extra or missing frame at the scoreboard, or as `busy`/`in_ready` being wrong in the idle cycle after the stop bit.

// File: rtl/fbtx_pkg.sv
package fbtx_pkg;
  localparam int CFG_W   = 32;
  localparam int PER_W   = 22;
  localparam int FRAC_W  = 6;
  localparam int PER_LSB = CFG_W - PER_W;
  localparam int LEN_W   = 5;
  localparam int MAX_BITS = 2 ** LEN_W;
  localparam logic [PER_W-1:0] PER_MIN = PER_W'(2 << FRAC_W);

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [LEN_W-1:0] len_m1;
  } frame_cfg_t;
endpackage

// File: rtl/fbtx_cfg.sv
module fbtx_cfg
  import fbtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             load,
  output frame_cfg_t       cfg_eff
);
  frame_cfg_t       cfg_q;
  frame_cfg_t       cfg_dec;
  logic [PER_W-1:0] per_raw;
  logic             unused_cfg_bits;

  assign per_raw         = cfg_word[PER_LSB +: PER_W];
  assign unused_cfg_bits = ^cfg_word[PER_LSB-1:LEN_W];

  always_comb begin
    cfg_dec.period = (per_raw < PER_MIN) ? PER_MIN : per_raw;
    cfg_dec.len_m1 = cfg_word[LEN_W-1:0];
  end

  // frame settings captured only at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.period <= PER_MIN;
      cfg_q.len_m1 <= LEN_W'(7);
    end else if (load) begin
      cfg_q <= cfg_dec;
    end
  end

  assign cfg_eff = load ? cfg_dec : cfg_q;

  assert_period_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.period >= PER_MIN);
  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
endmodule

// File: rtl/fbtx_timer.sv
module fbtx_timer
  import fbtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             bit_end
);
  localparam int INT_W = PER_W - FRAC_W + 1;

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] frac;
  logic [PER_W:0]    sum;

  // leftover fraction plus one period gives the next bit length
  always_comb begin
    sum = {1'b0, period};
    if (!start) sum = sum + {{(PER_W + 1 - FRAC_W){1'b0}}, frac};
  end

  assign bit_end = run && (cnt == INT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      frac <= '0;
    end else if (start || bit_end) begin
      cnt  <= sum[PER_W:FRAC_W];
      frac <= sum[FRAC_W-1:0];
    end else if (run) begin
      cnt <= cnt - INT_W'(1);
    end
  end

  assert_cnt_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt != '0);
  assert_reload_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start || bit_end) |=> cnt >= INT_W'(2));
endmodule

// File: rtl/fbtx_shift.sv
module fbtx_shift
  import fbtx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] data,
  input  logic [LEN_W-1:0]    len_m1,
  input  logic                step,
  output logic                txd,
  output logic                last
);
  localparam int SH_W  = MAX_BITS + 2;
  localparam int CNT_W = $clog2(MAX_BITS + 3);

  logic [SH_W-1:0]     shreg;
  logic [MAX_BITS-1:0] data_m;
  logic [CNT_W-1:0]    left;

  // bits past the selected length become stop-level ones
  for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_mask
    assign data_m[gi] = (LEN_W'(gi) <= len_m1) ? data[gi] : 1'b1;
  end

  assign last = step && (left == CNT_W'(1));
  assign txd  = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
    end else if (load) begin
      shreg <= {1'b1, data_m, 1'b0};
      left  <= CNT_W'(len_m1) + CNT_W'(3);
    end else if (step) begin
      shreg <= {1'b1, shreg[SH_W-1:1]};
      left  <= left - CNT_W'(1);
    end
  end

  assert_left_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> left != '0);
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> txd);
endmodule

// File: rtl/fbaud_uart_tx.sv
module fbaud_uart_tx
  import fbtx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_BITS-1:0] in_data,
  output logic                txd,
  output logic                busy
);
  logic       active;
  logic       accept;
  logic       bit_end;
  logic       done;
  frame_cfg_t cfg_eff;

  assign accept   = in_valid && !active;
  assign in_ready = !active;
  assign busy     = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      active <= 1'b0;
    else if (accept) active <= 1'b1;
    else if (done)   active <= 1'b0;
  end

  fbtx_cfg i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .load     (accept),
    .cfg_eff  (cfg_eff)
  );

  fbtx_timer i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (active),
    .period  (cfg_eff.period),
    .bit_end (bit_end)
  );

  fbtx_shift i_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .data   (in_data),
    .len_m1 (cfg_eff.len_m1),
    .step   (bit_end),
    .txd    (txd),
    .last   (done)
  );

  assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !txd);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> active);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);
endmodule

// File: tb/test_fbaud_uart_tx.sv
module test_fbaud_uart_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [31:0] data;
    longint      per;
    int          len;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] cfg_word = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [31:0] in_data = 0;
  logic        txd;
  logic        busy;

  int   checks = 0;
  int   errors = 0;
  int   sent = 0;
  int   seen = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fbaud_uart_tx i_fbaud_uart_tx (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .busy(busy)
  );

  function automatic logic [31:0] mk(input int per, input int len);
    return {per[21:0], 5'b10101, len[4:0]};
  endfunction

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: waits for ready, presents word, records expectation
  task automatic send(input logic [31:0] d, input logic [31:0] cfg);
    exp_t e;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cfg_word = cfg; in_data = d; in_valid = 1;
    e.data = d;
    e.per  = (cfg[31:10] < 22'd128) ? 128 : longint'(cfg[31:10]);
    e.len  = int'(cfg[4:0]);
    sb.push_back(e);
    sent++;
    @(negedge clk);
    in_valid = 0;
    in_data  = 32'hDEAD_BEEF;
  endtask

  // monitor: compares each line cycle with floor(k*P/64) edges (R3 R4 R8 R9)
  longint total, k;
  logic   expb;
  bit     bad;
  exp_t   cur;
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        seen++;
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected frame, actual start bit, expected idle line");
          while (txd === 1'b0) @(negedge clk);
        end else begin
          cur   = sb.pop_front();
          total = ((cur.len + 3) * cur.per) >> 6;
          bad   = 0;
          for (longint i = 0; i < total; i++) begin
            if (i > 0) @(negedge clk);
            k = 0;
            while ((((k + 1) * cur.per) >> 6) <= i) k++;
            if (k == 0) expb = 1'b0;
            else if (k <= cur.len + 1) expb = cur.data[k-1];
            else expb = 1'b1;
            if (!bad && (txd !== expb || busy !== 1'b1)) begin
              bad = 1;
              $display("FAIL R4/R3/R8: frame data %h cycle %0d actual txd=%b busy=%b expected txd=%b busy=1",
                       cur.data, i, txd, busy, expb);
            end
          end
          checks++;
          if (bad) errors++;
          @(negedge clk);
          checks++;
          if (txd !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R9: after stop actual txd=%b busy=%b ready=%b expected 1 0 1",
                     txd, busy, in_ready);
          end
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (txd !== 1 || busy !== 0 || in_ready !== 1) begin
      errors++;
      $display("FAIL R2: reset actual txd=%b busy=%b ready=%b expected 1 0 1", txd, busy, in_ready);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    checks++;
    if (txd !== 1 || busy !== 0 || in_ready !== 1) begin
      errors++;
      $display("FAIL R2: idle actual txd=%b busy=%b ready=%b expected 1 0 1", txd, busy, in_ready);
    end

    send(32'h0000_00A5, mk(512, 7));           // R1 R3 whole period, 8N1
    send(32'h0000_003C, mk(336, 7));           // R4 5.25 clocks
    send(32'h0000_00C3, mk(193, 7));           // R4 3.015625 clocks
    send(32'h0000_0096, mk(0, 7));             // R5 zero period clamps
    send(32'h0000_0069, mk(100, 7));           // R5 below 2.0 clamps
    send(32'hFFFF_FFFE, mk(150, 0));           // R8 single data bit
    send(32'h8123_4567, mk(170, 31));          // R8 32 data bits
    send(32'h0000_07E5, mk(260, 4));           // R8 upper bits not sent

    send(32'h0000_005A, mk(640, 7));           // R7 config changed mid-frame
    @(negedge clk);
    cfg_word = mk(200, 3);
    send(32'h0000_000B, mk(200, 3));

    send(32'h0000_0033, mk(640, 9));           // R6 valid while busy
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1; in_data = 32'h0000_0100 + j;
    end
    @(negedge clk);
    in_valid = 0;

    send(32'h0000_0011, mk(213, 7));           // R9 back to back
    send(32'h0000_00EE, mk(213, 7));

    while (sb.size() != 0 || busy) @(negedge clk);
    repeat (20) @(negedge clk);
    checks++;
    if (seen != sent) begin
      errors++;
      $display("FAIL R6: frames actual %0d expected %0d", seen, sent);
    end
    finished = 1;
    finish_up();
  end
endmodule